// File: doc/BRIEF.md
# QPP interleaver address generator

This block produces the interleaved read-address sequence that the second component decoder of a turbo decoder uses to fetch its systematic and a-priori values. A single start pulse selects one of eight block sizes. The block then emits the addresses f(x) = (f2·x² + f1·x) mod N for x = 0 … N-1, one per clock, with a valid flag and a flag on the final address. When the final address has been sent, it returns to idle.

The two coefficients are not computed from N. They come from a small internal table indexed by the size select. The address stream is built incrementally, so no multiplier is involved. Two running values are kept: the address f and its increment g. Each clock adds g to f and adds the constant 2·f2 to g. Every addition is taken mod N by one compare and one conditional subtraction.

Integrators feed the address stream straight to the memory holding the de-interleaved data. The valid flag qualifies each read, and the last flag closes the half iteration.

The controller has two states:
- ST_IDLE: waits for a start pulse.
- ST_RUN: emits one address per cycle.

The transitions are:
- ST_IDLE → ST_RUN when start is high. This loads N, f = 0, g = (f1+f2) mod N, and the step 2·f2 mod N.
- ST_RUN → ST_RUN while the current index is below N-1.
- ST_RUN → ST_IDLE in the cycle that carries index N-1.

Top module: `qpp_addr_gen`

## Requirements
- R1: After reset, valid_o and last_o are low and stay low until a start pulse is sampled.
- R2: The first address, 0, appears with valid_o high in the cycle right after the clock edge that samples start_i high in idle.
- R3: While running, valid_o stays high for N consecutive cycles. The k-th valid address (k from 0) equals (f2·k² + f1·k) mod N.
- R4: last_o is high only together with the address of index N-1. valid_o is low in the following cycle.
- R5: A start pulse sampled while a sequence is running has no effect on the addresses, their count or their timing.
- R6: size_sel_i selects the triple (N, f1, f2) as follows:
  - 0 → (40, 3, 10)
  - 1 → (48, 7, 12)
  - 2 → (56, 19, 42)
  - 3 → (64, 7, 16)
  - 4 → (104, 7, 26)
  - 5 → (512, 31, 64)
  - 6 → (1024, 31, 64)
  - 7 → (6144, 263, 480)
- R7: The N addresses of one sequence are a permutation of 0 … N-1.
- R8: Every valid address is below N.
- R9: size_sel_i is sampled only with an accepted start. Changing it during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a sequence; honoured only in idle |
| size_sel_i | input | 3 | Block-size select, sampled with start |
| addr_o | output | 13 | Interleaved address |
| valid_o | output | 1 | addr_o holds a sequence address |
| last_o | output | 1 | addr_o is the final address of the sequence |

## Verification
The address of index k is due k+1 cycles after the clock edge that samples the start pulse. The flag drop is due one cycle after last. The bench drives start at a falling edge and pushes all N expected addresses, computed by direct multiplication and modulo, into a queue at that same moment. The monitor samples at every falling edge and pops one entry per valid cycle, so an address that arrives early, late, repeated or missing shows up as a mismatch. Separate checks confirm that valid is up at the first falling edge after start, and that valid is down one falling edge after the queue drains.

// File: rtl/qpp_pkg.sv
package qpp_pkg;

    localparam int QPP_ADDR_W = 13;
    localparam int QPP_SEL_W  = 3;

    typedef logic [QPP_ADDR_W-1:0] qaddr_t;

    typedef struct packed {
        qaddr_t n;
        qaddr_t f1;
        qaddr_t f2;
    } qpp_coef_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } qpp_state_e;

    // Representative subset of block sizes with their polynomial coefficients
    function automatic qpp_coef_t qpp_coef_entry(input logic [QPP_SEL_W-1:0] sel);
        qpp_coef_t c;
        case (sel)
            3'd0:    begin c.n = 13'd40;   c.f1 = 13'd3;   c.f2 = 13'd10;  end
            3'd1:    begin c.n = 13'd48;   c.f1 = 13'd7;   c.f2 = 13'd12;  end
            3'd2:    begin c.n = 13'd56;   c.f1 = 13'd19;  c.f2 = 13'd42;  end
            3'd3:    begin c.n = 13'd64;   c.f1 = 13'd7;   c.f2 = 13'd16;  end
            3'd4:    begin c.n = 13'd104;  c.f1 = 13'd7;   c.f2 = 13'd26;  end
            3'd5:    begin c.n = 13'd512;  c.f1 = 13'd31;  c.f2 = 13'd64;  end
            3'd6:    begin c.n = 13'd1024; c.f1 = 13'd31;  c.f2 = 13'd64;  end
            default: begin c.n = 13'd6144; c.f1 = 13'd263; c.f2 = 13'd480; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/qpp_modadd.sv
// (a + b) mod m for a, b < m: one add, one conditional subtract
module qpp_modadd #(
    parameter int W = 13
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] m_i,
    output logic [W-1:0] y_o
);
    logic [W:0] sum;
    logic [W:0] diff;

    assign sum  = {1'b0, a_i} + {1'b0, b_i};
    assign diff = sum - {1'b0, m_i};
    assign y_o  = (sum >= {1'b0, m_i}) ? diff[W-1:0] : sum[W-1:0];
endmodule

// File: rtl/qpp_coef_rom.sv
module qpp_coef_rom
    import qpp_pkg::*;
#(
    parameter int SEL_W = QPP_SEL_W
) (
    input  logic [SEL_W-1:0] sel_i,
    output qpp_coef_t        coef_o
);
    assign coef_o = qpp_coef_entry(sel_i);
endmodule

// File: rtl/qpp_addr_gen.sv
module qpp_addr_gen
    import qpp_pkg::*;
#(
    parameter int ADDR_W = QPP_ADDR_W,
    parameter int SEL_W  = QPP_SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SEL_W-1:0]  size_sel_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              valid_o,
    output logic              last_o
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    qpp_state_e        state_q, state_d;
    logic [ADDR_W-1:0] n_q, f_q, g_q, step_q, idx_q;
    logic [ADDR_W-1:0] g_init, step_init, f_next, g_next;
    logic              at_end;
    qpp_coef_t         coef;

    qpp_coef_rom #(.SEL_W(SEL_W)) u_rom (
        .sel_i  (size_sel_i),
        .coef_o (coef)
    );

    // Seed values from the table entry
    qpp_modadd #(.W(ADDR_W)) u_g_init (
        .a_i (coef.f1), .b_i (coef.f2), .m_i (coef.n), .y_o (g_init)
    );
    qpp_modadd #(.W(ADDR_W)) u_step_init (
        .a_i (coef.f2), .b_i (coef.f2), .m_i (coef.n), .y_o (step_init)
    );

    // Running recursion
    qpp_modadd #(.W(ADDR_W)) u_f_next (
        .a_i (f_q), .b_i (g_q), .m_i (n_q), .y_o (f_next)
    );
    qpp_modadd #(.W(ADDR_W)) u_g_next (
        .a_i (g_q), .b_i (step_q), .m_i (n_q), .y_o (g_next)
    );

    assign at_end = (idx_q == (n_q - ONE));

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RUN;
            ST_RUN:  if (at_end)  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q    <= '0;
            f_q    <= '0;
            g_q    <= '0;
            step_q <= '0;
            idx_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        n_q    <= coef.n;
                        f_q    <= '0;
                        g_q    <= g_init;
                        step_q <= step_init;
                        idx_q  <= '0;
                    end
                end
                ST_RUN: begin
                    f_q   <= f_next;
                    g_q   <= g_next;
                    idx_q <= idx_q + ONE;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        valid_o = 1'b0;
        last_o  = 1'b0;
        addr_o  = f_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN: begin
                valid_o = 1'b1;
                last_o  = at_end;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/qpp_addr_gen_chk.sv
module qpp_addr_gen_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              valid_o,
    input logic              last_o,
    input logic [ADDR_W-1:0] blk_n
);
    AST_ADDR_BELOW_N: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (addr_o < blk_n)); // R8

    AST_FIRST_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !valid_o) |=> (valid_o && addr_o == '0)); // R2

    AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o); // R4

    AST_LAST_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !valid_o); // R4

    AST_RUN_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> valid_o); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && !start_i) |=> !valid_o); // R1
endmodule

bind qpp_addr_gen qpp_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .addr_o  (addr_o),
    .valid_o (valid_o),
    .last_o  (last_o),
    .blk_n   (n_q)
);

// File: tb/qpp_addr_gen_tb.sv
module qpp_addr_gen_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  size_sel_i = '0;
    logic [12:0] addr_o;
    logic        valid_o;
    logic        last_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    typedef struct {
        int    addr;
        bit    last;
        int    idx;
        int    n;
        string req;
    } exp_t;

    exp_t q[$];
    exp_t e;
    bit   seen[0:8191];
    int   distinct;
    int   got;

    qpp_addr_gen u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .size_sel_i (size_sel_i),
        .addr_o     (addr_o),
        .valid_o    (valid_o),
        .last_o     (last_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R6 table as stated in the requirements
    task automatic coef(input int sel, output int n, output int f1, output int f2);
        case (sel)
            0: begin n = 40;   f1 = 3;   f2 = 10;  end
            1: begin n = 48;   f1 = 7;   f2 = 12;  end
            2: begin n = 56;   f1 = 19;  f2 = 42;  end
            3: begin n = 64;   f1 = 7;   f2 = 16;  end
            4: begin n = 104;  f1 = 7;   f2 = 26;  end
            5: begin n = 512;  f1 = 31;  f2 = 64;  end
            6: begin n = 1024; f1 = 31;  f2 = 64;  end
            default: begin n = 6144; f1 = 263; f2 = 480; end
        endcase
    endtask

    // Monitor: pop and compare at every falling edge
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (q.size() == 0) begin
                chk(1'b0, "R3 unexpected valid", addr_o, -1);
            end else begin
                e = q.pop_front();
                if (e.idx == 0) begin
                    for (int i = 0; i < 8192; i++) seen[i] = 1'b0;
                    distinct = 0;
                    got = 0;
                end
                got++;
                chk(int'(addr_o) == e.addr, e.req, addr_o, e.addr);
                chk(last_o == e.last, "R4 last flag", last_o, e.last);
                chk(int'(addr_o) < e.n, "R8 range", addr_o, e.n);
                if (int'(addr_o) < e.n) begin
                    chk(!seen[addr_o], "R7 repeated address", addr_o, -1);
                    if (!seen[addr_o]) distinct++;
                    seen[addr_o] = 1'b1;
                end
                if (e.last) begin
                    chk(distinct == e.n, "R7 distinct count", distinct, e.n);
                    chk(got == e.n, "R6 sequence length", got, e.n);
                end
            end
        end
    end

    // Driver: mode 0 plain, 1 start pulse mid-run, 2 select change mid-run
    task automatic run_block(input int sel, input int mode);
        int n, f1, f2;
        string tag;
        coef(sel, n, f1, f2);
        tag = (mode == 1) ? "R5 address" : (mode == 2) ? "R9 address" : "R3 address";
        @(negedge clk);
        start_i    = 1'b1;
        size_sel_i = 3'(sel);
        for (int x = 0; x < n; x++) begin
            exp_t it;
            it.addr = int'((longint'(f2) * x * x + longint'(f1) * x) % n);
            it.last = (x == n - 1);
            it.idx  = x;
            it.n    = n;
            it.req  = tag;
            q.push_back(it);
        end
        @(negedge clk);
        start_i = 1'b0;
        chk(valid_o && addr_o == 13'd0, "R2 first address", addr_o, 0);
        if (mode == 1) begin
            repeat (5) @(negedge clk);
            start_i    = 1'b1;
            size_sel_i = 3'(7 - sel);
            @(negedge clk);
            start_i = 1'b0;
        end else if (mode == 2) begin
            repeat (3) @(negedge clk);
            size_sel_i = 3'(7 - sel);
        end
        wait (q.size() == 0);
        @(negedge clk);
        chk(!valid_o, "R4 idle after last", valid_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!valid_o && !last_o, "R1 reset outputs", {valid_o, last_o}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!valid_o, "R1 idle without start", valid_o, 0);
        for (int s = 0; s < 8; s++) run_block(s, 0);
        run_block(1, 1);
        run_block(3, 2);
        run_block(0, 1);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule